// File: doc/BRIEF.md
# Byte-Serial Instruction Length Decoder

This block takes a stream of instruction bytes, at most one per clock, and marks where each variable-length instruction begins and ends. Each instruction may start with up to four prefix bytes. An opcode of one byte follows, or of two bytes when the first is the escape value 0F. After the opcode there may be an addressing-mode byte, a scale-index byte, a displacement and an immediate. The size of each of these later fields depends on bytes seen earlier, so the decoder walks the instruction one byte at a time.

One clock after the last byte of an instruction, the decoder pulses an end flag. With that flag it reports the byte count, the number of prefixes, and whether the address-size or operand-size override was present. A small built-in opcode table decides whether an opcode takes a mode byte and which immediate it takes. Opcodes outside that table end the instruction at once and raise a flag. An extra prefix beyond the limit, or an instruction longer than the limit, ends the current instruction with an error. The next byte then starts a new instruction.

Top module: `insn_len_decoder`

## Requirements
- R1: While reset is held low, and on the first cycle after release, the outputs sop, eop, unk and err are 0, and len, pfx_n, asz16 and osz16 are 0.
- R2: A cycle with in_vld low accepts no byte. It gives sop=0 and eop=0 on the next cycle and leaves the decode state as it was.
- R3: The bytes F0, F2, F3, 26, 2E, 36, 3E, 64, 65, 66 and 67 are prefixes when they appear before the opcode. They are counted into pfx_n. A 66 prefix sets osz16 and a 67 prefix sets asz16. Both flags are reported with the instruction and are cleared for the next one.
- R4: One-byte opcode classes:
  - In the range 00-3F, low bits 0-3 take a mode byte, low bits 4 take an imm8, low bits 5 take an immZ, and low bits 6-7 take nothing.
  - 40-5F, 90-97, C3 and F4 take nothing.
  - 70-7F, B0-B7 and EB take an imm8.
  - B8-BF, E8 and E9 take an immZ.
  - 84-8B and 8D take a mode byte.
  - 80, 83 and C6 take a mode byte and an imm8.
  - 81 and C7 take a mode byte and an immZ.
  - immZ is 4 bytes, or 2 bytes when a 66 prefix is present.
- R5: An opcode byte 0F is followed by a second opcode byte. 80-8F then take an immZ, and AF, B6 and B7 take a mode byte.
- R6: Mode byte fields are mod in bits 7:6 and r/m in bits 2:0. With 32-bit addressing:
  - mod!=11 with r/m=100 adds a scale-index byte.
  - mod=01 adds 1 displacement byte.
  - mod=10 adds 4 displacement bytes.
  - mod=00 with r/m=101 adds 4 displacement bytes.
  - mod=00 with scale-index bits 2:0 equal to 101 adds 4 displacement bytes.
- R7: With a 67 prefix (16-bit addressing), no scale-index byte is used. mod=01 adds 1 displacement byte, and mod=10 or mod=00 with r/m=110 adds 2 displacement bytes.
- R8: The immediate bytes follow the displacement. The instruction ends on the last immediate byte.
- R9: An opcode outside the tables of R4 and R5 ends the instruction on that byte, with unk=1 for one cycle together with eop.
- R10: A prefix arriving when MAX_PFX prefixes are already counted ends the instruction on that byte. It reports err=1, len=MAX_PFX+1 and pfx_n=MAX_PFX, and the next byte starts a new instruction.
- R11: The byte numbered MAX_LEN+1 of any instruction ends it with err=1 and len=MAX_LEN+1, and the next byte starts a new instruction. An instruction of exactly MAX_LEN bytes has no error.
- R12: sop pulses one cycle after the first byte of an instruction is accepted, and eop pulses one cycle after the last byte. len equals the number of bytes accepted for that instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | A byte is present on in_byte this cycle |
| in_byte | input | 8 | Instruction stream byte |
| sop | output | 1 | Pulse: the byte accepted last cycle began an instruction |
| eop | output | 1 | Pulse: the byte accepted last cycle ended an instruction |
| len | output | LW = $clog2(MAX_LEN+2) | Byte count of the instruction, updated with eop |
| pfx_n | output | PW = $clog2(MAX_PFX+1) | Prefix count, updated with eop |
| asz16 | output | 1 | 16-bit address override seen, updated with eop |
| osz16 | output | 1 | 16-bit operand override seen, updated with eop |
| unk | output | 1 | Pulse with eop: opcode not in the table |
| err | output | 1 | Pulse with eop: prefix or length limit exceeded |

## Verification
The bench builds the decoder with MAX_PFX=4 and MAX_LEN=12. With those values a legal instruction of the longest form (a prefix, an opcode, a mode byte, a scale-index byte, a 4-byte displacement and a 4-byte immediate) lands exactly on the length limit. Adding two more prefixes pushes it over, so the overflow error, and the resynchronisation part-way through an immediate, can be reached with ordinary opcodes. At the default of 15 bytes, no opcode in the table can reach that case. The fifth-prefix error and the 16-bit displacement forms are driven as well, with idle gaps mixed into the stream.

// File: rtl/insn_len_decoder.sv
module insn_len_decoder #(
  parameter int MAX_PFX = 4,
  parameter int MAX_LEN = 15,
  localparam int LW = $clog2(MAX_LEN + 2),
  localparam int PW = $clog2(MAX_PFX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [7:0]    in_byte,
  output logic          sop,
  output logic          eop,
  output logic [LW-1:0] len,
  output logic [PW-1:0] pfx_n,
  output logic          asz16,
  output logic          osz16,
  output logic          unk,
  output logic          err
);
  typedef enum logic [2:0] {S_PFX, S_OP2, S_MRM, S_SIB, S_DSP, S_IMM} st_t;

  st_t st, st_n;
  logic [LW-1:0] cnt;
  logic [PW-1:0] pfx;
  logic a16, o16;
  logic [2:0] rem, rem_n, imm_n, imm_nn, dsz, isz;
  logic [1:0] md, md_n;
  logic fin, bad, pfx_hit, unk_c, sib, opc;
  logic [3:0] c;

  // {unknown, mode byte, imm kind: 0 none, 1 imm8, 2 immZ}
  function automatic logic [3:0] cls(input logic two, input logic [7:0] op);
    logic [3:0] r;
    r = 4'b1000;
    if (two) begin
      if (op[7:4] == 4'h8) r = 4'b0010;
      else if (op == 8'hAF || op == 8'hB6 || op == 8'hB7) r = 4'b0100;
    end else if (op < 8'h40) begin
      case (op[2:0])
        3'd4: r = 4'b0001;
        3'd5: r = 4'b0010;
        3'd6, 3'd7: r = 4'b0000;
        default: r = 4'b0100;
      endcase
    end else if (op < 8'h60 || op[7:3] == 5'b10010 || op == 8'hC3 || op == 8'hF4) r = 4'b0000;
    else if (op[7:4] == 4'h7 || op == 8'hEB || op[7:3] == 5'b10110) r = 4'b0001;
    else if (op[7:3] == 5'b10111 || op == 8'hE8 || op == 8'hE9) r = 4'b0010;
    else if (op == 8'h80 || op == 8'h83 || op == 8'hC6) r = 4'b0101;
    else if (op == 8'h81 || op == 8'hC7) r = 4'b0110;
    else if ((op >= 8'h84 && op <= 8'h8B) || op == 8'h8D) r = 4'b0100;
    return r;
  endfunction

  wire is_pfx = (in_byte == 8'hF0) || (in_byte == 8'hF2) || (in_byte == 8'hF3) ||
                (in_byte == 8'h26) || (in_byte == 8'h2E) || (in_byte == 8'h36) ||
                (in_byte == 8'h3E) || (in_byte == 8'h64) || (in_byte == 8'h65) ||
                (in_byte == 8'h66) || (in_byte == 8'h67);
  wire [1:0] mo = in_byte[7:6];
  wire [2:0] rm = in_byte[2:0];

  assign c   = cls(st == S_OP2, in_byte);
  assign isz = (c[1:0] == 2'd1) ? 3'd1 : (c[1:0] == 2'd2) ? (o16 ? 3'd2 : 3'd4) : 3'd0;
  assign opc = (st == S_OP2) || (st == S_PFX && !is_pfx && in_byte != 8'h0F);

  always_comb begin
    sib = 1'b0;
    dsz = 3'd0;
    if (st == S_SIB) begin
      if (md == 2'd1) dsz = 3'd1;
      else if (md == 2'd2 || (md == 2'd0 && rm == 3'd5)) dsz = 3'd4;
    end else if (a16) begin
      if (mo == 2'd1) dsz = 3'd1;
      else if (mo == 2'd2 || (mo == 2'd0 && rm == 3'd6)) dsz = 3'd2;
    end else begin
      sib = (mo != 2'd3) && (rm == 3'd4);
      if (mo == 2'd1) dsz = 3'd1;
      else if (mo == 2'd2 || (mo == 2'd0 && rm == 3'd5)) dsz = 3'd4;
    end
  end

  always_comb begin
    st_n = st; rem_n = rem; imm_nn = imm_n; md_n = md;
    fin = 1'b0; bad = 1'b0; pfx_hit = 1'b0; unk_c = 1'b0;
    if (opc) begin
      if (c[3]) begin fin = 1'b1; unk_c = 1'b1; end
      else if (c[2]) begin st_n = S_MRM; imm_nn = isz; end
      else if (isz != 3'd0) begin st_n = S_IMM; rem_n = isz; end
      else fin = 1'b1;
    end else begin
      case (st)
        S_PFX: begin
          if (!is_pfx) st_n = S_OP2;
          else if (pfx == PW'(MAX_PFX)) bad = 1'b1;
          else pfx_hit = 1'b1;
        end
        S_MRM, S_SIB: begin
          if (sib && st == S_MRM) begin st_n = S_SIB; md_n = mo; end
          else if (dsz != 3'd0) begin st_n = S_DSP; rem_n = dsz; end
          else if (imm_n != 3'd0) begin st_n = S_IMM; rem_n = imm_n; end
          else fin = 1'b1;
        end
        S_DSP: begin
          if (rem != 3'd1) rem_n = rem - 3'd1;
          else if (imm_n != 3'd0) begin st_n = S_IMM; rem_n = imm_n; end
          else fin = 1'b1;
        end
        default: begin
          if (rem == 3'd1) fin = 1'b1;
          else rem_n = rem - 3'd1;
        end
      endcase
    end
    if (cnt == LW'(MAX_LEN)) bad = 1'b1;
    if (bad) begin fin = 1'b1; unk_c = 1'b0; end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_PFX; cnt <= '0; pfx <= '0; a16 <= 1'b0; o16 <= 1'b0;
      rem <= 3'd0; imm_n <= 3'd0; md <= 2'd0;
      sop <= 1'b0; eop <= 1'b0; unk <= 1'b0; err <= 1'b0;
      len <= '0; pfx_n <= '0; asz16 <= 1'b0; osz16 <= 1'b0;
    end else begin
      sop <= in_vld && (cnt == '0);
      eop <= in_vld && fin;
      unk <= in_vld && unk_c;
      err <= in_vld && bad;
      if (in_vld) begin
        if (fin) begin
          len <= cnt + 1'b1; pfx_n <= pfx; asz16 <= a16; osz16 <= o16;
          st <= S_PFX; cnt <= '0; pfx <= '0; a16 <= 1'b0; o16 <= 1'b0;
          rem <= 3'd0; imm_n <= 3'd0;
        end else begin
          st <= st_n; cnt <= cnt + 1'b1; rem <= rem_n; imm_n <= imm_nn; md <= md_n;
          if (pfx_hit) begin
            pfx <= pfx + 1'b1;
            if (in_byte == 8'h67) a16 <= 1'b1;
            if (in_byte == 8'h66) o16 <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/insn_len_decoder_chk.sv
module insn_len_decoder_chk #(
  parameter int MAX_PFX = 4,
  parameter int MAX_LEN = 15,
  localparam int LW = $clog2(MAX_LEN + 2),
  localparam int PW = $clog2(MAX_PFX + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_vld,
  input logic          sop,
  input logic          eop,
  input logic [LW-1:0] len,
  input logic [PW-1:0] pfx_n,
  input logic          unk,
  input logic          err
);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!sop && !eop));
  assert_err_on_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> eop);
  assert_unk_on_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unk |-> (eop && !err));
  assert_len_limit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eop && !err) |-> (len >= LW'(1) && len <= LW'(MAX_LEN)));
  assert_pfx_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eop |-> (pfx_n <= PW'(MAX_PFX)));
  assert_short_err_is_pfx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eop && err && len <= LW'(MAX_LEN)) |-> (pfx_n == PW'(MAX_PFX)));
  assert_single_byte_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sop && eop) |-> (len == LW'(1)));
endmodule

bind insn_len_decoder insn_len_decoder_chk #(.MAX_PFX(MAX_PFX), .MAX_LEN(MAX_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .sop(sop), .eop(eop),
  .len(len), .pfx_n(pfx_n), .unk(unk), .err(err)
);

// File: tb/insn_len_decoder_tb.sv
`timescale 1ns/1ps
module insn_len_decoder_tb_top;
  localparam int MAXP = 4;
  localparam int MAXL = 12;
  localparam int LW = $clog2(MAXL + 2);
  localparam int PW = $clog2(MAXP + 1);

  logic clk = 1'b0, rst_n = 1'b0, in_vld = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic sop, eop, asz16, osz16, unk, err;
  logic [LW-1:0] len;
  logic [PW-1:0] pfx_n;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  insn_len_decoder #(.MAX_PFX(MAXP), .MAX_LEN(MAXL)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte),
    .sop(sop), .eop(eop), .len(len), .pfx_n(pfx_n),
    .asz16(asz16), .osz16(osz16), .unk(unk), .err(err));

  logic [7:0] stream[$];
  bit e_sop[$], e_eop[$], e_a[$], e_o[$], e_u[$], e_e[$];
  int e_len[$], e_np[$];
  string e_tag[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit ref_pfx(input logic [7:0] b);
    return b inside {8'hF0, 8'hF2, 8'hF3, 8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'h66, 8'h67};
  endfunction

  // m: mode byte present; k: 0 none, 1 imm8, 2 immZ; u: unknown
  function automatic void ref_cls(input bit two, input logic [7:0] op, output bit m, output int k, output bit u);
    m = 0; k = 0; u = 0;
    if (two) begin
      if (op >= 8'h80 && op <= 8'h8F) k = 2;
      else if (op inside {8'hAF, 8'hB6, 8'hB7}) m = 1;
      else u = 1;
    end else if (op <= 8'h3F) begin
      if (op % 8 < 4) m = 1;
      else if (op % 8 == 4) k = 1;
      else if (op % 8 == 5) k = 2;
    end else if (op <= 8'h5F || (op >= 8'h90 && op <= 8'h97) || op == 8'hC3 || op == 8'hF4) begin
    end else if ((op >= 8'h70 && op <= 8'h7F) || (op >= 8'hB0 && op <= 8'hB7) || op == 8'hEB) k = 1;
    else if ((op >= 8'hB8 && op <= 8'hBF) || op == 8'hE8 || op == 8'hE9) k = 2;
    else if (op inside {8'h80, 8'h83, 8'hC6}) begin m = 1; k = 1; end
    else if (op inside {8'h81, 8'hC7}) begin m = 1; k = 2; end
    else if ((op >= 8'h84 && op <= 8'h8B) || op == 8'h8D) m = 1;
    else u = 1;
  endfunction

  function automatic void ref_dec(input int p, output int ln, output int np, output bit a, output bit o,
                                  output bit u, output bit e, output string tag);
    int i, k;
    bit two, m;
    logic [7:0] op, mr, sb;
    i = p; np = 0; a = 0; o = 0; u = 0; e = 0; tag = "R4";
    while (ref_pfx(stream[i])) begin
      if (np == MAXP) begin
        e = 1; ln = i - p + 1; tag = "R10";
        return;
      end
      np++;
      if (stream[i] == 8'h66) o = 1;
      if (stream[i] == 8'h67) a = 1;
      i++;
    end
    two = 0; op = stream[i]; i++;
    if (op == 8'h0F) begin two = 1; op = stream[i]; i++; end
    ref_cls(two, op, m, k, u);
    if (u) begin
      ln = i - p; tag = "R9";
    end else begin
      tag = two ? "R5" : (k != 0 ? "R8" : "R4");
      if (m) begin
        mr = stream[i]; i++;
        tag = two ? "R5" : (a ? "R7" : "R6");
        if (a) begin
          if (mr[7:6] == 1) i += 1;
          else if (mr[7:6] == 2 || (mr[7:6] == 0 && mr[2:0] == 6)) i += 2;
        end else begin
          if (mr[7:6] != 3 && mr[2:0] == 4) begin
            sb = stream[i]; i++;
            if (mr[7:6] == 0 && sb[2:0] == 5) i += 4;
          end
          if (mr[7:6] == 1) i += 1;
          else if (mr[7:6] == 2 || (mr[7:6] == 0 && mr[2:0] == 5)) i += 4;
        end
      end
      if (k == 1) i += 1;
      else if (k == 2) i += (o ? 2 : 4);
      ln = i - p;
    end
    if (ln > MAXL) begin e = 1; u = 0; ln = MAXL + 1; tag = "R11"; end
  endfunction

  int pend = -1;

  task automatic step(input int idx);
    @(negedge clk);
    if (pend < 0) begin
      chk(sop == 1'b0 && eop == 1'b0, "R2", "idle sop/eop", {sop, eop}, 0);
    end else begin
      chk(sop == e_sop[pend], "R12", "sop", sop, e_sop[pend]);
      chk(eop == e_eop[pend], "R12", "eop", eop, e_eop[pend]);
      if (e_eop[pend]) begin
        chk(int'(len) == e_len[pend], e_tag[pend], "len", len, e_len[pend]);
        chk(int'(pfx_n) == e_np[pend], "R3", "pfx_n", pfx_n, e_np[pend]);
        chk(asz16 == e_a[pend], "R3", "asz16", asz16, e_a[pend]);
        chk(osz16 == e_o[pend], "R3", "osz16", osz16, e_o[pend]);
        chk(unk == e_u[pend], "R9", "unk", unk, e_u[pend]);
        chk(err == e_e[pend], e_tag[pend], "err", err, e_e[pend]);
      end
    end
    if (idx < 0) begin in_vld = 1'b0; in_byte = 8'h00; end
    else begin in_vld = 1'b1; in_byte = stream[idx]; end
    pend = idx;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int p, ln, np;
    bit a, o, u, e;
    string tag;
    stream = {stream, 8'h90, 8'h04, 8'h7F, 8'h05, 8'h11, 8'h22, 8'h33, 8'h44};
    stream = {stream, 8'h66, 8'h05, 8'h11, 8'h22, 8'h01, 8'hC8, 8'h8B, 8'h45, 8'h10};
    stream = {stream, 8'h8B, 8'h04, 8'h88, 8'h8B, 8'h05, 8'h01, 8'h02, 8'h03, 8'h04};
    stream = {stream, 8'h8B, 8'h44, 8'h24, 8'h08, 8'h8B, 8'h04, 8'h25, 8'hA1, 8'hA2, 8'hA3, 8'hA4};
    stream = {stream, 8'h8B, 8'h84, 8'h88, 8'hB1, 8'hB2, 8'hB3, 8'hB4};
    stream = {stream, 8'h67, 8'h8B, 8'h46, 8'h10, 8'h67, 8'h8B, 8'h06, 8'h11, 8'h22};
    stream = {stream, 8'h67, 8'h8B, 8'h80, 8'h11, 8'h22, 8'h67, 8'h8B, 8'h04};
    stream = {stream, 8'h0F, 8'h84, 8'h01, 8'h02, 8'h03, 8'h04, 8'h66, 8'h0F, 8'h85, 8'h11, 8'h22};
    stream = {stream, 8'h0F, 8'hB6, 8'hC1, 8'h0F, 8'h0B, 8'hD6, 8'hF3, 8'hF2, 8'hD6};
    stream = {stream, 8'hC7, 8'h80, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
    stream = {stream, 8'hF0, 8'h2E, 8'h66, 8'h67, 8'hC7, 8'h46, 8'h10, 8'h11, 8'h22};
    stream = {stream, 8'hF0, 8'hF2, 8'hF3, 8'h64, 8'h65, 8'h90};
    stream = {stream, 8'h26, 8'h2E, 8'hF0, 8'hC7, 8'h84, 8'h24, 8'h11, 8'h22, 8'h33, 8'h44,
                      8'h55, 8'h66, 8'h77, 8'h90};
    stream = {stream, 8'hF0, 8'hC7, 8'h84, 8'h24, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88};
    stream = {stream, 8'hEB, 8'h05, 8'hE8, 8'h01, 8'h02, 8'h03, 8'h04, 8'hB0, 8'h12};
    stream = {stream, 8'hB8, 8'h01, 8'h02, 8'h03, 8'h04, 8'h70, 8'h10, 8'h40};
    stream = {stream, 8'h83, 8'hC0, 8'h01, 8'h80, 8'h38, 8'h05, 8'hC3, 8'hF4, 8'h3D, 8'h01, 8'h02, 8'h03, 8'h04};

    foreach (stream[i]) begin
      e_sop.push_back(0); e_eop.push_back(0); e_a.push_back(0); e_o.push_back(0);
      e_u.push_back(0); e_e.push_back(0); e_len.push_back(0); e_np.push_back(0); e_tag.push_back("");
    end
    p = 0;
    while (p < stream.size()) begin
      ref_dec(p, ln, np, a, o, u, e, tag);
      e_sop[p] = 1;
      e_eop[p + ln - 1] = 1;
      e_len[p + ln - 1] = ln; e_np[p + ln - 1] = np;
      e_a[p + ln - 1] = a; e_o[p + ln - 1] = o;
      e_u[p + ln - 1] = u; e_e[p + ln - 1] = e;
      e_tag[p + ln - 1] = tag;
      p += ln;
    end

    repeat (3) @(negedge clk);
    chk({sop, eop, unk, err, asz16, osz16} == 6'b0 && len == '0 && pfx_n == '0,
        "R1", "outputs in reset", {sop, eop, unk, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({sop, eop, unk, err} == 4'b0 && len == '0, "R1", "outputs after release", {sop, eop, unk, err}, 0);

    for (int i = 0; i < stream.size(); i++) begin
      if (i % 5 == 3) step(-1);
      step(i);
    end
    step(-1);
    step(-1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule